// File: doc/BRIEF.md
# Instruction Cache Synonym Hazard Detector

This block sits beside the fetch path of a 16 KB, two-way instruction cache whose arrays are indexed by effective address while tags are matched against the translated real address. Each way holds 8 KB, so address bits 12 down to 2 (LSB-0 numbering) pick a word within a way. When the smallest pages are in use, some of those index bits are also translated bits. The same real line can then be reached through more than one index, which creates a synonym.

For every fetch presented with a valid strobe, the detector takes the effective address, the real address, a 3-bit page-size code and the translate-enable bit. One cycle later it reports three things. The first is whether the index window overlaps translated bits. The second is the largest number of places one real line could occupy. The third is whether this particular effective/real pair actually disagrees in the overlapping bits. In real mode, with translation off, it never reports a hazard.

Top module: `syn_hazard_detect`

## Requirements
- R1: `outValid` is high in the cycle after a cycle with `inValid` high, and low otherwise. Results appear with exactly one register stage of latency.
- R2: Page codes are 0=1 KB, 1=4 KB, 2=16 KB, 3=64 KB, 4=256 KB, 5=1 MB, 6=4 MB, 7=16 MB. The page offset of code c is 10+2c bits wide.
- R3: With translation on and code 0, `overlap` is 1 and `synCount` is 8. The compared bits are address bits 12, 11 and 10.
- R4: With translation on and code 1, `overlap` is 1 and `synCount` is 2. Only address bit 12 is compared.
- R5: With translation on and codes 2 to 7, `overlap` is 0, `synCount` is 1 and `mismatch` is 0, whatever the addresses are.
- R6: `mismatch` is 1 exactly when the effective and real addresses differ in at least one compared bit. Differences in any other bit have no effect.
- R7: With translation off (`xlateEn`=0), `overlap` is 0, `synCount` is 1 and `mismatch` is 0 for any page code and addresses.
- R8: While `inValid` is low, `overlap`, `synCount` and `mismatch` keep their last values.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Lookup strobe |
| effAddr | input | 32 | Effective fetch address |
| realAddr | input | 32 | Translated real address |
| pageSize | input | 3 | Page-size code (see R2) |
| xlateEn | input | 1 | Instruction translation enabled |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| overlap | output | 1 | Index bits overlap translated bits |
| synCount | output | 4 | Maximum synonym count (8, 2 or 1) |
| mismatch | output | 1 | Pair disagrees in an overlapping bit |

## Verification
The 1 KB page code is tried with pairs that differ only in bit 11, only in bit 10 or only in bit 12. It is also tried with pairs that agree in bits 12..10 but differ in higher and lower bits. Together these show that the whole three-bit window, and nothing else, is compared. The 4 KB code gets a difference in bit 11 and then one in bit 12, which shows that its window has narrowed to one bit. Every larger code, and real mode, is driven with pairs that differ everywhere, to show the hazard is suppressed. Gaps without a strobe and a pseudo-random sweep then check holding, latency and the mix of all cases.

// File: rtl/synhaz_pkg.sv
package synhaz_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;      // capture a new result this cycle
    logic realMode;  // translation off: force the no-hazard answer
  } ctrlStrobe_t;
endpackage

// File: rtl/synhaz_ctrl.sv
module synhaz_ctrl
  import synhaz_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        xlateEn,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.load     = inValid;
    strobe.realMode = !xlateEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/synhaz_dp.sv
module synhaz_dp
  import synhaz_pkg::*;
#(
  parameter int WAY_LOG2      = 13, // bytes per way, log2
  parameter int MIN_PAGE_LOG2 = 10, // smallest page, log2
  parameter int PAGE_STEP     = 2,  // log2 growth per page code
  parameter int PSIZE_W       = 3,
  parameter int CNT_W         = 4,
  localparam int OVL_W        = WAY_LOG2 - MIN_PAGE_LOG2,
  localparam int NUM_CODES    = 1 << PSIZE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [OVL_W-1:0]   eaWin,
  input  logic [OVL_W-1:0]   raWin,
  input  logic [PSIZE_W-1:0] pageSize,
  output logic               overlapQ,
  output logic [CNT_W-1:0]   synCountQ,
  output logic               mismatchQ
);
  logic [OVL_W-1:0] maskByCode  [NUM_CODES];
  logic [CNT_W-1:0] countByCode [NUM_CODES];

  // One constant compare mask and synonym count per page code
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam int PAGE_LOG2 = MIN_PAGE_LOG2 + PAGE_STEP * c;
    localparam int NOVL      = (PAGE_LOG2 < WAY_LOG2) ? (WAY_LOG2 - PAGE_LOG2) : 0;
    for (genvar j = 0; j < OVL_W; j++) begin : g_bit
      assign maskByCode[c][j] = ((MIN_PAGE_LOG2 + j) >= PAGE_LOG2);
    end
    assign countByCode[c] = CNT_W'(1 << NOVL);
  end

  logic [OVL_W-1:0] activeMask;
  logic             nextOverlap;
  logic [CNT_W-1:0] nextCount;
  logic             nextMismatch;

  always_comb begin
    activeMask   = strobe.realMode ? '0 : maskByCode[pageSize];
    nextOverlap  = |activeMask;
    nextCount    = strobe.realMode ? CNT_W'(1) : countByCode[pageSize];
    nextMismatch = |((eaWin ^ raWin) & activeMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overlapQ  <= 1'b0;
      synCountQ <= '0;
      mismatchQ <= 1'b0;
    end else if (strobe.load) begin
      overlapQ  <= nextOverlap;
      synCountQ <= nextCount;
      mismatchQ <= nextMismatch;
    end
  end
endmodule

// File: rtl/syn_hazard_detect.sv
module syn_hazard_detect
  import synhaz_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WAY_LOG2      = 13,
  parameter int MIN_PAGE_LOG2 = 10,
  parameter int PAGE_STEP     = 2,
  parameter int PSIZE_W       = 3,
  parameter int CNT_W         = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ADDR_W-1:0]  effAddr,
  input  logic [ADDR_W-1:0]  realAddr,
  input  logic [PSIZE_W-1:0] pageSize,
  input  logic               xlateEn,
  output logic               outValid,
  output logic               overlap,
  output logic [CNT_W-1:0]   synCount,
  output logic               mismatch
);
  ctrlStrobe_t strobe;

  synhaz_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .xlateEn  (xlateEn),
    .strobe   (strobe),
    .outValid (outValid)
  );

  synhaz_dp #(
    .WAY_LOG2      (WAY_LOG2),
    .MIN_PAGE_LOG2 (MIN_PAGE_LOG2),
    .PAGE_STEP     (PAGE_STEP),
    .PSIZE_W       (PSIZE_W),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .eaWin     (effAddr[WAY_LOG2-1:MIN_PAGE_LOG2]),
    .raWin     (realAddr[WAY_LOG2-1:MIN_PAGE_LOG2]),
    .pageSize  (pageSize),
    .overlapQ  (overlap),
    .synCountQ (synCount),
    .mismatchQ (mismatch)
  );
endmodule

// File: rtl/synhaz_chk.sv
module synhaz_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             xlateEn,
  input logic             outValid,
  input logic             overlap,
  input logic [CNT_W-1:0] synCount,
  input logic             mismatch
);
  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R6
  mismatch_needs_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> overlap);
  // R5
  single_count_when_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !overlap) |-> (synCount == CNT_W'(1)));
  // R3
  count_power_of_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(synCount) == 1));
  // R7
  real_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !xlateEn) |=> (!overlap && !mismatch));
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(overlap) && $stable(synCount) && $stable(mismatch)));
endmodule

bind syn_hazard_detect synhaz_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .xlateEn  (xlateEn),
  .outValid (outValid),
  .overlap  (overlap),
  .synCount (synCount),
  .mismatch (mismatch)
);

// File: tb/syn_hazard_detect_tb.sv
module syn_hazard_detect_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] effAddr, realAddr;
  logic [2:0]  pageSize;
  logic        xlateEn;
  logic        outValid, overlap, mismatch;
  logic [3:0]  synCount;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference state
  bit         eValid, eOver, eMis;
  logic [3:0] eCnt;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk; // 50 MHz

  syn_hazard_detect u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .effAddr(effAddr),
    .realAddr(realAddr), .pageSize(pageSize), .xlateEn(xlateEn),
    .outValid(outValid), .overlap(overlap), .synCount(synCount),
    .mismatch(mismatch)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural model of the requirements, applied for one strobe
  task automatic model(input bit v, input logic [31:0] ea, input logic [31:0] ra,
                       input int ps, input bit xe);
    int lo;
    eValid = v;
    if (!v) return;
    lo = 10 + 2 * ps;
    eOver = 0; eMis = 0; eCnt = 4'd1;
    if (xe && lo < 13) begin
      eOver = 1;
      eCnt = 4'(1 << (13 - lo));
      for (int b = lo; b < 13; b++)
        if (ea[b] != ra[b]) eMis = 1;
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge
  task automatic step(input string req, input bit v, input logic [31:0] ea,
                      input logic [31:0] ra, input int ps, input bit xe);
    inValid = v; effAddr = ea; realAddr = ra; pageSize = 3'(ps); xlateEn = xe;
    model(v, ea, ra, ps, xe);
    @(negedge clk);
    chk(req, "outValid", int'(outValid), int'(eValid));
    chk(req, "overlap",  int'(overlap),  int'(eOver));
    chk(req, "synCount", int'(synCount), int'(eCnt));
    chk(req, "mismatch", int'(mismatch), int'(eMis));
  endtask

  initial begin
    rstN = 1'b0; inValid = 0; effAddr = '0; realAddr = '0; pageSize = '0; xlateEn = 0;
    eValid = 0; eOver = 0; eMis = 0; eCnt = '0;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "outValid", int'(outValid), 0);
    chk("R9", "overlap",  int'(overlap),  0);
    chk("R9", "synCount", int'(synCount), 0);
    chk("R9", "mismatch", int'(mismatch), 0);
    rstN = 1'b1;
    step("R9", 0, 32'h0, 32'hFFFF_FFFF, 0, 1); // idle after reset: still zero

    // R3: 1 KB window, each bit alone, then agreeing window
    step("R3", 1, 32'h0000_0800, 32'h0000_0000, 0, 1);
    step("R3", 1, 32'h0000_0400, 32'h0000_0000, 0, 1);
    step("R3", 1, 32'h0000_1000, 32'h0000_0000, 0, 1);
    // R6: differences outside the window only
    step("R6", 1, 32'h1234_1DFC, 32'hABCD_1C03, 0, 1);
    // R4: 4 KB, bit 11 differs (ignored) then bit 12 differs
    step("R4", 1, 32'h0000_0800, 32'h0000_0000, 1, 1);
    step("R4", 1, 32'h0000_1000, 32'h0000_0000, 1, 1);
    // R5 and R2: larger codes with full disagreement
    for (int c = 2; c < 8; c++) step("R5", 1, 32'hFFFF_FFFF, 32'h0000_0000, c, 1);
    // R7: real mode, every code
    for (int c = 0; c < 8; c++) step("R7", 1, 32'hFFFF_FFFF, 32'h0000_0000, c, 0);
    // R8: load a hazard, then idle cycles with new inputs
    step("R8", 1, 32'h0000_1C00, 32'h0000_0000, 0, 1);
    step("R8", 0, 32'h0, 32'h0, 7, 0);
    step("R8", 0, 32'h0, 32'h0, 2, 1);
    // R1: back-to-back strobes
    step("R1", 1, 32'h0000_0400, 32'h0000_0400, 0, 1);
    step("R1", 1, 32'h0000_1000, 32'h0000_0000, 1, 1);
    // R2: pseudo-random sweep
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, r;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; a = lfsr * 32'h9E37_79B9;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; r = lfsr * 32'h85EB_CA6B;
      step("R2", a[0] | a[5], a, r, int'(r[2:0]), r[7] | r[9]);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule